// File: doc/BRIEF.md
# Three-stage pipelined integer core

A compact 32-bit integer core built as a three-stage pipeline. The first stage issues an instruction address. The second stage decodes the returned word, reads its source registers and resolves control flow. The third stage computes the result and writes it back to the register file in the same cycle. Instruction words come in on one port and data goes out on another, so a fetch and a load or store never compete. After a two-cycle fill, one instruction retires every clock.

The core does not stall and does not flush. Branches and jumps have one delay slot, and the instruction that follows a branch or jump always executes. Loads have one delay slot, so the instruction right after a load still sees the register's previous value. Both memories are synchronous. The instruction memory returns the word for an address one cycle after the address is presented. The data memory returns load data one cycle after the load's address. The instruction subset covers add-immediate, register add, branch-on-equal, jump-and-link, word load and word store. Any other opcode retires as a no-op.

Top module: `pipe3_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `imem_addr` is 0 and `dmem_we` and `dmem_re` are low. The pipeline holds only bubbles.
- R2: Add-immediate (bits [31:26]=0x08, source in [25:21], destination in [20:16], immediate in [15:0]) writes source plus the sign-extended immediate.
- R3: Register add (bits [31:26]=0x00 with [5:0]=0x20, sources in [25:21] and [20:16], destination in [15:11]) writes the sum of the two sources. Any other value in [5:0] is a no-op.
- R4: Register 0 always reads as zero, and any write to it is discarded.
- R5: An arithmetic result is visible to the instruction that immediately follows it, including as store data.
- R6: Branch-on-equal (bits [31:26]=0x04, compared registers in [25:21] and [20:16]) always executes its delay slot. When taken, it fetches from the delay-slot address plus the sign-extended [15:0] shifted left by two. The word after the delay slot is then never fetched. When not taken, fetch continues in sequence.
- R7: Jump-and-link (bits [31:26]=0x03) always executes its delay slot. It then fetches from {delay-slot address [31:28], bits [25:0], 2'b00} and writes its own address plus 8 into register 31.
- R8: Word load (0x23) and word store (0x2B) use the address in register [25:21] plus the sign-extended [15:0]. The register in [20:16] is the load destination or the store data. Only these two instructions drive `dmem_we` or `dmem_re`, never both in one cycle. Load data is taken from `dmem_rdata` one cycle after `dmem_re`.
- R9: The instruction right after a load reads the register's old value. The instruction after that reads the loaded value.
- R10: An undefined opcode changes no register, memory or fetch order.
- R11: Fetch addresses are word aligned and advance by 4 every cycle unless a branch or jump redirects them. An instruction issued in cycle i after reset reaches the data port in cycle i+2, giving one retirement per clock after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word for the address of the previous cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for the address of the previous cycle |

## Verification
The checker watches, on every cycle, the reset entry state of the fetch address and the data port, the word alignment and sequential stepping of fetch around non-control opcodes, and the exclusion of simultaneous load and store. Register results, forwarding into the next instruction, the two delay slots and the redirect targets can only be seen in the bench's program. That program exposes them through the ordered sequence of stores and the set of fetched addresses.

// File: rtl/p3_pkg.sv
package p3_pkg;
    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int NREGS   = 1 << RIDX_W;
    localparam int OP_W    = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREGS - 1);

    localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OP_W-1:0] OPC_JAL  = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OP_W-1:0] OPC_LW   = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW   = 6'h2B;
    localparam logic [5:0]      FN_ADD   = 6'h20;

    typedef enum logic [1:0] {
        EXK_NONE  = 2'd0,
        EXK_ARITH = 2'd1,
        EXK_LOAD  = 2'd2,
        EXK_STORE = 2'd3
    } exk_e;

    typedef struct packed {
        logic              valid;
        exk_e              kind;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   sdata;
    } exstage_t;

    typedef struct packed {
        logic              en;
        logic [RIDX_W-1:0] idx;
        logic [XLEN-1:0]   data;
    } wport_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/p3_fetch.sv
module p3_fetch
    import p3_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc,
    output logic            dec_valid,
    output logic [XLEN-1:0] dec_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= RESET_PC;
            dec_valid <= 1'b0;
            dec_pc    <= RESET_PC;
        end else begin
            pc        <= redirect ? target : pc + STEP;
            dec_valid <= 1'b1;
            dec_pc    <= pc;
        end
    end
endmodule

// File: rtl/p3_regfile.sv
module p3_regfile
    import p3_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                           clk,
    input  logic [NRD-1:0][RIDX_W-1:0]     raddr,
    output logic [NRD-1:0][XLEN-1:0]       rdata,
    input  wport_t                         wr_new,
    input  wport_t                         wr_old
);
    logic [XLEN-1:0] regs [NREGS];

    // wr_new belongs to the younger instruction, so it is applied last
    always_ff @(posedge clk) begin
        if (wr_old.en && wr_old.idx != '0) regs[wr_old.idx] <= wr_old.data;
        if (wr_new.en && wr_new.idx != '0) regs[wr_new.idx] <= wr_new.data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [XLEN-1:0] val;
        always_comb begin
            if (raddr[p] == '0)
                val = '0;
            else if (wr_new.en && wr_new.idx == raddr[p])
                val = wr_new.data;
            else if (wr_old.en && wr_old.idx == raddr[p])
                val = wr_old.data;
            else
                val = regs[raddr[p]];
        end
        assign rdata[p] = val;
    end
endmodule

// File: rtl/p3_decode.sv
module p3_decode
    import p3_pkg::*;
(
    input  logic                  dec_valid,
    input  logic [XLEN-1:0]       dec_pc,
    input  logic [XLEN-1:0]       instr,
    output logic [1:0][RIDX_W-1:0] src_idx,
    input  logic [1:0][XLEN-1:0]  src_val,
    output logic                  redirect,
    output logic [XLEN-1:0]       target,
    output exstage_t              ex_next
);
    logic [OP_W-1:0]   opc;
    logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
    logic [XLEN-1:0]   imm, slot_pc;

    assign opc     = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign imm     = sext_imm(instr[IMM_W-1:0]);
    assign slot_pc = dec_pc + XLEN'(4);
    assign src_idx = {f_rt, f_rs};

    always_comb begin
        ex_next  = '0;
        redirect = 1'b0;
        target   = slot_pc + (imm << 2);
        if (dec_valid) begin
            case (opc)
                OPC_ADDI: begin
                    ex_next.valid = 1'b1;
                    ex_next.kind  = EXK_ARITH;
                    ex_next.dst   = f_rt;
                    ex_next.opa   = src_val[0];
                    ex_next.opb   = imm;
                end
                OPC_REG: begin
                    if (instr[5:0] == FN_ADD) begin
                        ex_next.valid = 1'b1;
                        ex_next.kind  = EXK_ARITH;
                        ex_next.dst   = f_rd;
                        ex_next.opa   = src_val[0];
                        ex_next.opb   = src_val[1];
                    end
                end
                OPC_LW: begin
                    ex_next.valid = 1'b1;
                    ex_next.kind  = EXK_LOAD;
                    ex_next.dst   = f_rt;
                    ex_next.opa   = src_val[0];
                    ex_next.opb   = imm;
                end
                OPC_SW: begin
                    ex_next.valid = 1'b1;
                    ex_next.kind  = EXK_STORE;
                    ex_next.opa   = src_val[0];
                    ex_next.opb   = imm;
                    ex_next.sdata = src_val[1];
                end
                OPC_BEQ: begin
                    redirect = (src_val[0] == src_val[1]);
                end
                OPC_JAL: begin
                    redirect      = 1'b1;
                    target        = {slot_pc[XLEN-1:XLEN-4], instr[TGT_W-1:0], 2'b00};
                    ex_next.valid = 1'b1;
                    ex_next.kind  = EXK_ARITH;
                    ex_next.dst   = LINK_REG;
                    ex_next.opa   = dec_pc + XLEN'(8);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/p3_execute.sv
module p3_execute
    import p3_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  exstage_t        ex_next,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata,
    output wport_t          wr_new,
    output wport_t          wr_old
);
    exstage_t          ex;
    logic              ld_pend;
    logic [RIDX_W-1:0] ld_dst;
    logic [XLEN-1:0]   sum;

    always_ff @(posedge clk) begin
        if (rst) ex <= '0;
        else     ex <= ex_next;
    end

    assign sum        = ex.opa + ex.opb;
    assign dmem_addr  = sum;
    assign dmem_wdata = ex.sdata;
    assign dmem_we    = ex.valid && ex.kind == EXK_STORE;
    assign dmem_re    = ex.valid && ex.kind == EXK_LOAD;

    assign wr_new.en   = ex.valid && ex.kind == EXK_ARITH && ex.dst != '0;
    assign wr_new.idx  = ex.dst;
    assign wr_new.data = sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_pend <= 1'b0;
            ld_dst  <= '0;
        end else begin
            ld_pend <= dmem_re && ex.dst != '0;
            ld_dst  <= ex.dst;
        end
    end

    assign wr_old.en   = ld_pend;
    assign wr_old.idx  = ld_dst;
    assign wr_old.data = dmem_rdata;
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
    import p3_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata
);
    logic                   redirect;
    logic [XLEN-1:0]        target;
    logic                   dec_valid;
    logic [XLEN-1:0]        dec_pc;
    logic [1:0][RIDX_W-1:0] src_idx;
    logic [1:0][XLEN-1:0]   src_val;
    exstage_t               ex_next;
    wport_t                 wr_new, wr_old;

    p3_fetch #(.RESET_PC(RESET_PC)) u_fetch (
        .clk(clk), .rst(rst), .redirect(redirect), .target(target),
        .pc(imem_addr), .dec_valid(dec_valid), .dec_pc(dec_pc)
    );

    p3_regfile #(.NRD(2)) u_rf (
        .clk(clk), .raddr(src_idx), .rdata(src_val),
        .wr_new(wr_new), .wr_old(wr_old)
    );

    p3_decode u_dec (
        .dec_valid(dec_valid), .dec_pc(dec_pc), .instr(imem_rdata),
        .src_idx(src_idx), .src_val(src_val),
        .redirect(redirect), .target(target), .ex_next(ex_next)
    );

    p3_execute u_ex (
        .clk(clk), .rst(rst), .ex_next(ex_next),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .wr_new(wr_new), .wr_old(wr_old)
    );
endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk #(
    parameter logic [31:0] RESET_PC = '0
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [5:0]  imem_op,
    input logic        dmem_we,
    input logic        dmem_re
);
    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> imem_addr == RESET_PC); // R1

    AST_RESET_DPORT_IDLE: assert property (@(posedge clk)
        rst |=> (!dmem_we && !dmem_re)); // R1

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00); // R11

    AST_FETCH_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (imem_op != 6'h03 && imem_op != 6'h04) |=> imem_addr == $past(imem_addr) + 32'd4); // R11

    AST_DPORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re)); // R8
endmodule

bind pipe3_core pipe3_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_op(imem_rdata[31:26]),
    .dmem_we(dmem_we), .dmem_re(dmem_re)
);

// File: tb/pipe3_core_tb.sv
module pipe3_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pipe3_core u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
    );

    // memories: synchronous, one cycle read latency
    logic [31:0] imem [64];
    logic [31:0] dmem [32];
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:2]];
        if (dmem_we) dmem[dmem_addr[6:2]] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr[6:2]];
    end

    // observation logs
    logic [31:0] st_addr [32];
    logic [31:0] st_data [32];
    int          st_n = 0;
    int          rd_n = 0;
    logic [31:0] rd_addr0 = '1;
    bit seen64 = 0, seen108 = 0, seen112 = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (dmem_we && st_n < 32) begin
                st_addr[st_n] = dmem_addr;
                st_data[st_n] = dmem_wdata;
                st_n++;
            end
            if (dmem_re) begin
                if (rd_n == 0) rd_addr0 = dmem_addr;
                rd_n++;
            end
            if (imem_addr == 32'd64)  seen64  = 1;
            if (imem_addr == 32'd108) seen108 = 1;
            if (imem_addr == 32'd112) seen112 = 1;
        end
    end

    function automatic logic [31:0] e_addi(int rt, int rs, int imm);
        return {6'h08, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_add(int rd, int rs, int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    endfunction
    function automatic logic [31:0] e_lw(int rt, int imm, int base);
        return {6'h23, 5'(base), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_sw(int rt, int imm, int base);
        return {6'h2B, 5'(base), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_beq(int rs, int rt, int imm);
        return {6'h04, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_jal(int widx);
        return {6'h03, 26'(widx)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected store stream {address, data}, in program order
    localparam logic [63:0] EXP_ST [12] = '{
        {32'd0,  32'd7},          // R3 R5: add result, stored by next instr
        {32'd4,  32'd2},          // R2 R5: 5 + (-3)
        {32'd8,  32'd0},          // R4: write to r0 ignored
        {32'd12, 32'hFFFF_FFFF},  // R2: sign-extended -1
        {32'd16, 32'd1},          // R9: load delay slot sees old value
        {32'd20, 32'd7},          // R9: next sees loaded value
        {32'd24, 32'd11},         // R6: taken branch, slot ran, skip word skipped
        {32'd28, 32'd7},          // R6: not taken, sequential path ran
        {32'd32, 32'd7},          // R10: undefined opcode left r7 alone
        {32'd60, 32'd5},          // R8: negative store offset
        {32'd36, 32'd21},         // R7: jump slot ran, skipped word did not
        {32'd40, 32'd108}         // R7: link = jal address + 8
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R3/R5";
            1: return "R2/R5";
            2: return "R4";
            3: return "R2";
            4, 5: return "R9";
            6, 7: return "R6";
            8: return "R10";
            9: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        for (int i = 0; i < 32; i++) dmem[i] = 32'h0;
        imem[0]  = e_addi(1, 0, 5);
        imem[1]  = e_addi(2, 1, -3);
        imem[2]  = e_add(3, 1, 2);
        imem[3]  = e_sw(3, 0, 0);
        imem[4]  = e_sw(2, 4, 0);
        imem[5]  = e_addi(0, 0, 9);
        imem[6]  = e_sw(0, 8, 0);
        imem[7]  = e_addi(4, 0, -1);
        imem[8]  = e_sw(4, 12, 0);
        imem[9]  = e_addi(5, 0, 1);
        imem[10] = e_addi(9, 0, 64);
        imem[11] = e_lw(5, 0, 0);
        imem[12] = e_sw(5, 16, 0);
        imem[13] = e_sw(5, 20, 0);
        imem[14] = e_beq(1, 1, 2);
        imem[15] = e_addi(6, 0, 11);
        imem[16] = e_addi(6, 0, 99);
        imem[17] = e_sw(6, 24, 0);
        imem[18] = e_beq(1, 2, 5);
        imem[19] = e_addi(7, 0, 3);
        imem[20] = e_addi(7, 7, 4);
        imem[21] = e_sw(7, 28, 0);
        imem[22] = {6'h3F, 5'd0, 5'd7, 16'h0055};
        imem[23] = e_sw(7, 32, 0);
        imem[24] = e_sw(1, -4, 9);
        imem[25] = e_jal(28);
        imem[26] = e_addi(8, 0, 21);
        imem[27] = e_addi(8, 0, 77);
        imem[28] = e_sw(8, 36, 0);
        imem[29] = e_sw(31, 40, 0);
        imem[30] = e_beq(0, 0, -1);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1", "reset fetch address", imem_addr, 32'd0);
        check(!dmem_we, "R1", "store strobe in reset", 32'(dmem_we), 32'd0);
        check(!dmem_re, "R1", "load strobe in reset", 32'(dmem_re), 32'd0);
        rst = 1'b0;

        // R11: sequential fetch and two-cycle fill
        k = 0;
        while (!dmem_we && k < 20) begin
            @(negedge clk);
            k++;
            if (k == 1) check(imem_addr == 32'd4, "R11", "fetch after 1 cycle", imem_addr, 32'd4);
            if (k == 2) check(imem_addr == 32'd8, "R11", "fetch after 2 cycles", imem_addr, 32'd8);
            if (k == 1) check(!dmem_we && !dmem_re, "R1", "data port first cycle", 32'({dmem_we, dmem_re}), 32'd0);
        end
        check(k == 5, "R11", "cycle of first store", 32'(k), 32'd5);
        check(dmem_addr == 32'd0, "R11", "first store address", dmem_addr, 32'd0);

        repeat (80) @(negedge clk);

        // table of expected stores
        check(st_n == 12, "R8", "store count", 32'(st_n), 32'd12);
        for (int i = 0; i < 12; i++) begin
            if (i < st_n) begin
                check(st_addr[i] == EXP_ST[i][63:32], tag_of(i), $sformatf("store %0d addr", i),
                      st_addr[i], EXP_ST[i][63:32]);
                check(st_data[i] == EXP_ST[i][31:0], tag_of(i), $sformatf("store %0d data", i),
                      st_data[i], EXP_ST[i][31:0]);
            end
        end

        // R8: single load, correct address
        check(rd_n == 1, "R8", "load count", 32'(rd_n), 32'd1);
        check(rd_addr0 == 32'd0, "R8", "load address", rd_addr0, 32'd0);

        // R6 / R7: redirects skip the word after the delay slot
        check(!seen64, "R6", "fetched word after branch slot", 32'(seen64), 32'd0);
        check(!seen108, "R7", "fetched word after jump slot", 32'(seen108), 32'd0);
        check(seen112, "R7", "jump target fetched", 32'(seen112), 32'd1);

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        check(imem_addr == 32'd0, "R1", "fetch address after mid-run reset", imem_addr, 32'd0);
        check(!dmem_we && !dmem_re, "R1", "data port after mid-run reset", 32'({dmem_we, dmem_re}), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule